// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is a single DMA channel that walks a chain of descriptors kept in memory. Software builds the chain, writes the address of its first element into a 64-bit list pointer, seeds the consumer cycle state, and rings the doorbell. The engine then reads descriptors one 32-bit word at a time through a simple memory read port. For each data element it hands the source address, destination address and byte count to an external datamover through a valid/ready copy-request port. Link elements redirect the walk to another address. A link element can also invert the consumer cycle state, which lets software reuse a ring without head or tail pointers.

An element counts as produced only when its cycle bit equals the consumer cycle state. When the engine meets an element that is not yet produced, it stops, parks its list pointer on that element and raises the stop interrupt. A later doorbell resumes the walk from there. A read error or a zero byte count aborts the channel. There are two interrupt sources, stop and abort. Each has a sticky status bit, a clear bit, a mask, and separate enables that route it to a local and a remote interrupt line.

Registers sit at word offsets on a 4-bit register address: 0 channel enable, 1 list-mode enable, 2 pointer low word, 3 pointer high word, 4 cycle sync, 5 doorbell, 6 interrupt setup, 7 interrupt status (read only), 8 interrupt clear (write only), 9 channel state (read only). Reads are combinational.

Top module: `lldma_channel`

## Requirements
- R1: After reset the channel state reads 0, the interrupt status reads 0, and both interrupt outputs are low.
- R2: Writing 1 to bit0 of the doorbell starts the walk at the list pointer. This happens only when bit0 of the channel enable and bit0 of the list-mode enable are both set and the channel is not running. Otherwise the doorbell has no effect: the state stays as it was and no copy request appears.
- R3: A data element is six words at consecutive 4-byte addresses: control, byte count, source low, source high, destination low, destination high. Control bit0 is the cycle bit, bit1 is toggle-cycle and bit2 marks a link element. Each produced data element yields exactly one copy request carrying its full 64-bit source, 64-bit destination and byte count. The next element is then read 24 bytes further on. Both pointer halves read back what was written while idle.
- R4: An element whose cycle bit differs from the consumer cycle state is not consumed. The channel state becomes 3, the stop status bit (bit0) is set, and the list pointer reads the address of that element.
- R5: A produced link element is three words: control, next-address low, next-address high. It moves the walk to the next address. If its toggle-cycle bit is set, the consumer cycle state inverts; otherwise it is kept. Bit0 of the cycle sync register reads and seeds the consumer cycle state.
- R6: A read error on any descriptor word, or a data element with a zero byte count, aborts the channel. The channel state becomes 2, the abort status bit (bit1) is set, and no copy request is issued for that element.
- R7: Writing 1 to bit0 or bit1 of the interrupt clear register zeroes the matching status bit. Writing 0 leaves it unchanged.
- R8: Interrupt setup bits are: bit0 stop mask, bit1 abort mask, bit2 local stop enable, bit3 local abort enable, bit4 remote stop enable, bit5 remote abort enable. A source drives the local or remote output high while its status bit is set, its mask bit is clear and its enable bit for that output is set.
- R9: The channel state reads 1 from the doorbell until the walk stops or aborts, and no memory or copy request is issued outside that state.
- R10: A memory request holds its address until acknowledged, and all descriptor reads are word aligned. A copy request holds its fields until the datamover accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response carries an error |
| cp_valid | output | 1 | Copy request valid |
| cp_ready | input | 1 | Datamover accepts the request |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_size | output | 32 | Copy byte count |
| irq_local | output | 1 | Local interrupt line |
| irq_remote | output | 1 | Remote interrupt line |

## Verification
The walk is driven through several chain shapes. The first is a straight run of data elements that ends on a link whose cycle bit is inverted, which separates the produced elements from the stop point. The second is a one-element ring closed by a toggling link, replayed after software flips the cycle bits, which tells toggling apart from mere jumping. The third is a non-toggling link into a short run, which shows that the cycle state is kept. Faulty chains (a zero count, and an error on the source word) separate the abort path from the stop path. Varied stalls on the datamover side exercise the hold behaviour of the copy port, and the interrupt mask and enable combinations show that status recording and line routing act independently.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
   // channel state field encoding
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_RUN   = 2'd1,
      CH_ABORT = 2'd2,
      CH_DONE  = 2'd3
   } ch_state_e;

   // walker sequencing states
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_COPY  = 2'd2
   } wk_state_e;

   // descriptor control word bits
   localparam int CW_CYCLE  = 0;
   localparam int CW_TOGGLE = 1;
   localparam int CW_LINK   = 2;

   // descriptor geometry in 32-bit words
   localparam int DATA_WORDS = 6;
   localparam int LINK_WORDS = 3;

   // interrupt status bits
   localparam int IRQ_STOP  = 0;
   localparam int IRQ_ABORT = 1;
   localparam int IRQ_SETUP_W = 6;

   // register word offsets
   localparam logic [3:0] RG_ENABLE = 4'd0;
   localparam logic [3:0] RG_LLEN   = 4'd1;
   localparam logic [3:0] RG_PTR_LO = 4'd2;
   localparam logic [3:0] RG_PTR_HI = 4'd3;
   localparam logic [3:0] RG_CYCLE  = 4'd4;
   localparam logic [3:0] RG_DOORB  = 4'd5;
   localparam logic [3:0] RG_ISETUP = 4'd6;
   localparam logic [3:0] RG_ISTAT  = 4'd7;
   localparam logic [3:0] RG_ICLEAR = 4'd8;
   localparam logic [3:0] RG_CHST   = 4'd9;
endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
   import lldma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [3:0] reg_addr,
   input  logic       wbit0,
   output logic       ptr_lo_we,
   output logic       ptr_hi_we,
   output logic       ccs_we,
   output logic       setup_we,
   output logic       clear_we,
   output logic       start,
   output logic       chan_en,
   output logic       list_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_en <= 1'b0;
         list_en <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == RG_ENABLE) chan_en <= wbit0;
         if (reg_addr == RG_LLEN)   list_en <= wbit0;
      end
   end

   assign ptr_lo_we = reg_we && (reg_addr == RG_PTR_LO);
   assign ptr_hi_we = reg_we && (reg_addr == RG_PTR_HI);
   assign ccs_we    = reg_we && (reg_addr == RG_CYCLE);
   assign setup_we  = reg_we && (reg_addr == RG_ISETUP);
   assign clear_we  = reg_we && (reg_addr == RG_ICLEAR);
   assign start     = reg_we && (reg_addr == RG_DOORB) && wbit0 && chan_en && list_en;
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
   import lldma_pkg::*;
#(
   parameter int AW = 64,
   parameter int SW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ptr_lo_we,
   input  logic          ptr_hi_we,
   input  logic          ccs_we,
   input  logic [31:0]   wdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_err,
   output logic          cp_valid,
   input  logic          cp_ready,
   output logic [AW-1:0] cp_src,
   output logic [AW-1:0] cp_dst,
   output logic [SW-1:0] cp_size,
   output logic [AW-1:0] cur_ptr,
   output logic          ccs,
   output ch_state_e     ch_state,
   output logic          ev_stop,
   output logic          ev_abort
);
   localparam int WIX_W = $clog2(DATA_WORDS);
   localparam logic [WIX_W-1:0] LINK_LAST = WIX_W'(LINK_WORDS - 1);
   localparam logic [WIX_W-1:0] DATA_LAST = WIX_W'(DATA_WORDS - 1);
   localparam logic [AW-1:0]    DATA_STEP = AW'(DATA_WORDS * 4);

   wk_state_e        st_q;
   ch_state_e        chs_q;
   logic [WIX_W-1:0] wix_q;
   logic [2:0]       ctl_q;
   logic [SW-1:0]    size_q;
   logic [AW-1:0]    src_q, dst_q, ptr_q;
   logic [31:0]      nlo_q;
   logic             ccs_q;
   logic             beat, is_link;

   assign beat     = (st_q == WK_FETCH) && mem_ack;
   assign is_link  = ctl_q[CW_LINK];
   assign ev_stop  = beat && !mem_err && (wix_q == '0) && (mem_rdata[CW_CYCLE] != ccs_q);
   assign ev_abort = beat && (mem_err ||
                     ((wix_q == WIX_W'(1)) && !is_link && (mem_rdata[SW-1:0] == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WK_IDLE;
         chs_q  <= CH_IDLE;
         wix_q  <= '0;
         ctl_q  <= '0;
         size_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         ptr_q  <= '0;
         nlo_q  <= '0;
         ccs_q  <= 1'b0;
      end else begin
         case (st_q)
            WK_IDLE: begin
               if (start) begin
                  st_q  <= WK_FETCH;
                  chs_q <= CH_RUN;
                  wix_q <= '0;
               end else begin
                  if (ptr_lo_we) ptr_q[31:0]    <= wdata;
                  if (ptr_hi_we) ptr_q[AW-1:32] <= wdata[AW-33:0];
                  if (ccs_we)    ccs_q          <= wdata[0];
               end
            end
            WK_FETCH: begin
               if (mem_ack) begin
                  if (ev_abort) begin
                     st_q  <= WK_IDLE;
                     chs_q <= CH_ABORT;
                  end else if (ev_stop) begin
                     st_q  <= WK_IDLE;
                     chs_q <= CH_DONE;
                  end else begin
                     wix_q <= wix_q + 1'b1;
                     if (wix_q == '0) begin
                        ctl_q <= mem_rdata[2:0];
                     end else if (is_link) begin
                        if (wix_q == LINK_LAST) begin
                           ptr_q <= {mem_rdata[AW-33:0], nlo_q};
                           ccs_q <= ccs_q ^ ctl_q[CW_TOGGLE];
                           wix_q <= '0;
                        end else begin
                           nlo_q <= mem_rdata;
                        end
                     end else begin
                        case (wix_q)
                           WIX_W'(1): size_q          <= mem_rdata[SW-1:0];
                           WIX_W'(2): src_q[31:0]     <= mem_rdata;
                           WIX_W'(3): src_q[AW-1:32]  <= mem_rdata[AW-33:0];
                           WIX_W'(4): dst_q[31:0]     <= mem_rdata;
                           default: begin
                              dst_q[AW-1:32] <= mem_rdata[AW-33:0];
                              if (wix_q == DATA_LAST) st_q <= WK_COPY;
                           end
                        endcase
                     end
                  end
               end
            end
            WK_COPY: begin
               if (cp_ready) begin
                  ptr_q <= ptr_q + DATA_STEP;
                  wix_q <= '0;
                  st_q  <= WK_FETCH;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign mem_req  = (st_q == WK_FETCH);
   assign mem_addr = ptr_q + AW'({wix_q, 2'b00});
   assign cp_valid = (st_q == WK_COPY);
   assign cp_src   = src_q;
   assign cp_dst   = dst_q;
   assign cp_size  = size_q;
   assign cur_ptr  = ptr_q;
   assign ccs      = ccs_q;
   assign ch_state = chs_q;
endmodule

// File: rtl/lldma_irq.sv
module lldma_irq
   import lldma_pkg::*;
#(
   parameter bit REMOTE_IRQ = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   setup_we,
   input  logic                   clear_we,
   input  logic [IRQ_SETUP_W-1:0] wdata,
   input  logic                   ev_stop,
   input  logic                   ev_abort,
   output logic [IRQ_SETUP_W-1:0] setup,
   output logic [1:0]             stat,
   output logic                   irq_local,
   output logic                   irq_remote
);
   logic [1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup <= '0;
         stat  <= '0;
      end else begin
         if (setup_we) setup <= wdata;
         // a new event wins over a clear in the same cycle
         stat[IRQ_STOP]  <= ev_stop  | (stat[IRQ_STOP]  & ~(clear_we & wdata[IRQ_STOP]));
         stat[IRQ_ABORT] <= ev_abort | (stat[IRQ_ABORT] & ~(clear_we & wdata[IRQ_ABORT]));
      end
   end

   assign live      = stat & ~setup[1:0];
   assign irq_local = |(live & setup[3:2]);

   generate
      if (REMOTE_IRQ) begin : g_remote
         assign irq_remote = |(live & setup[5:4]);
      end else begin : g_no_remote
         assign irq_remote = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
   import lldma_pkg::*;
#(
   parameter int AW         = 64,
   parameter int SW         = 32,
   parameter bit REMOTE_IRQ = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_err,
   output logic          cp_valid,
   input  logic          cp_ready,
   output logic [AW-1:0] cp_src,
   output logic [AW-1:0] cp_dst,
   output logic [SW-1:0] cp_size,
   output logic          irq_local,
   output logic          irq_remote
);
   generate
      if (AW <= 32 || AW > 64) begin : g_bad_aw
         $error("lldma_channel: AW must lie in 33..64");
      end
      if (SW < 1 || SW > 32) begin : g_bad_sw
         $error("lldma_channel: SW must lie in 1..32");
      end
   endgenerate

   logic ptr_lo_we, ptr_hi_we, ccs_we, setup_we, clear_we, start;
   logic chan_en, list_en, ccs, ev_stop, ev_abort;
   logic [AW-1:0] cur_ptr;
   ch_state_e ch_status;
   logic [IRQ_SETUP_W-1:0] irq_setup;
   logic [1:0] irq_stat;

   lldma_regs u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .wbit0(reg_wdata[0]), .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we),
      .ccs_we(ccs_we), .setup_we(setup_we), .clear_we(clear_we),
      .start(start), .chan_en(chan_en), .list_en(list_en)
   );

   lldma_walker #(.AW(AW), .SW(SW)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .ptr_lo_we(ptr_lo_we),
      .ptr_hi_we(ptr_hi_we), .ccs_we(ccs_we), .wdata(reg_wdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err), .cp_valid(cp_valid),
      .cp_ready(cp_ready), .cp_src(cp_src), .cp_dst(cp_dst), .cp_size(cp_size),
      .cur_ptr(cur_ptr), .ccs(ccs), .ch_state(ch_status),
      .ev_stop(ev_stop), .ev_abort(ev_abort)
   );

   lldma_irq #(.REMOTE_IRQ(REMOTE_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .clear_we(clear_we),
      .wdata(reg_wdata[IRQ_SETUP_W-1:0]), .ev_stop(ev_stop), .ev_abort(ev_abort),
      .setup(irq_setup), .stat(irq_stat), .irq_local(irq_local),
      .irq_remote(irq_remote)
   );

   always_comb begin
      case (reg_addr)
         RG_ENABLE: reg_rdata = {31'b0, chan_en};
         RG_LLEN:   reg_rdata = {31'b0, list_en};
         RG_PTR_LO: reg_rdata = cur_ptr[31:0];
         RG_PTR_HI: reg_rdata = 32'(cur_ptr[AW-1:32]);
         RG_CYCLE:  reg_rdata = {31'b0, ccs};
         RG_ISETUP: reg_rdata = 32'(irq_setup);
         RG_ISTAT:  reg_rdata = 32'(irq_stat);
         RG_CHST:   reg_rdata = 32'(ch_status);
         default:   reg_rdata = 32'b0;
      endcase
   end
endmodule

// File: rtl/lldma_checker.sv
module lldma_checker #(
   parameter int AW = 64,
   parameter int SW = 32
)(
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic          cp_valid,
   input logic          cp_ready,
   input logic [AW-1:0] cp_src,
   input logic [AW-1:0] cp_dst,
   input logic [SW-1:0] cp_size,
   input logic [1:0]    ch_status,
   input logic          ev_stop,
   input logic          ev_abort,
   input logic [1:0]    irq_stat,
   input logic          irq_local,
   input logic          irq_remote
);
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
   AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00); // R10
   AST_CP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cp_valid && !cp_ready |=> cp_valid && $stable(cp_src) && $stable(cp_dst) && $stable(cp_size)); // R10
   AST_NO_ZERO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      cp_valid |-> cp_size != '0); // R6
   AST_REQ_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || cp_valid) |-> ch_status == 2'd1); // R9
   AST_STOP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> ch_status == 2'd3 && irq_stat[0]); // R4
   AST_ABORT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort |=> ch_status == 2'd2 && irq_stat[1]); // R6
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stat == 2'b00 |-> !irq_local && !irq_remote); // R8
endmodule

bind lldma_channel lldma_checker #(.AW(AW), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .cp_valid(cp_valid), .cp_ready(cp_ready),
   .cp_src(cp_src), .cp_dst(cp_dst), .cp_size(cp_size),
   .ch_status(ch_status), .ev_stop(ev_stop), .ev_abort(ev_abort),
   .irq_stat(irq_stat), .irq_local(irq_local), .irq_remote(irq_remote)
);

// File: tb/lldma_channel_test.sv
`timescale 1ns/1ps
module lldma_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_ack, mem_err;
   logic [63:0] mem_addr;
   logic [31:0] mem_rdata;
   logic        cp_valid, cp_ready;
   logic [63:0] cp_src, cp_dst;
   logic [31:0] cp_size;
   logic        irq_local, irq_remote;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [31:0] mem [0:1023];
   bit          err_en = 0;
   logic [63:0] err_addr = '0;
   logic [159:0] exp_q [$];
   int rdy_cnt = 0;

   always #4 clk = ~clk;

   lldma_channel uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_err(mem_err), .cp_valid(cp_valid), .cp_ready(cp_ready),
      .cp_src(cp_src), .cp_dst(cp_dst), .cp_size(cp_size),
      .irq_local(irq_local), .irq_remote(irq_remote)
   );

   // memory model: one response per request, one cycle later
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_err   <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack   <= mem_req && !mem_ack;
         mem_rdata <= mem[mem_addr[11:2]];
         mem_err   <= err_en && (mem_addr == err_addr);
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // scoreboard monitor with a stalling datamover
   always @(negedge clk) begin
      rdy_cnt++;
      cp_ready = (rdy_cnt % 3) != 0;
      if (rst_n && cp_valid && cp_ready) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R3: actual copy %h %h %h expected none", cp_src, cp_dst, cp_size);
         end else begin
            logic [159:0] e;
            e = exp_q.pop_front();
            if ({cp_src, cp_dst, cp_size} !== e) begin
               n_fail++;
               $display("FAIL R3: actual %h expected %h", {cp_src, cp_dst, cp_size}, e);
            end
         end
      end
   end

   task automatic expect_copy(input logic [63:0] s, input logic [63:0] d, input logic [31:0] n);
      exp_q.push_back({s, d, n});
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic put_data(input int a, input bit cyc, input logic [31:0] n,
                           input logic [63:0] s, input logic [63:0] d);
      mem[a/4]     = {31'b0, cyc};
      mem[a/4 + 1] = n;
      mem[a/4 + 2] = s[31:0];
      mem[a/4 + 3] = s[63:32];
      mem[a/4 + 4] = d[31:0];
      mem[a/4 + 5] = d[63:32];
   endtask

   task automatic put_link(input int a, input bit cyc, input bit tog, input logic [31:0] nxt);
      mem[a/4]     = {29'b0, 1'b1, tog, cyc};
      mem[a/4 + 1] = nxt;
      mem[a/4 + 2] = 32'h0;
   endtask

   task automatic wait_end();
      logic [31:0] v;
      int n = 0;
      do begin
         @(negedge clk);
         rd(4'd9, v);
         n++;
      end while (v == 32'd1 && n < 3000);
      if (n >= 3000) begin
         n_chk++; n_fail++;
         $display("FAIL R9: actual still running expected stop");
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic run_done(input string req, input logic [31:0] st, input logic [31:0] ptr);
      logic [31:0] v;
      wait_end();
      rd(4'd9, v); chk({req, " state"}, v, st);
      rd(4'd2, v); chk({req, " pointer"}, v, ptr);
      chk({req, " copies drained"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd9, v); chk("R1 state", v, 0);
      rd(4'd7, v); chk("R1 irq status", v, 0);
      chk("R1 lines", {irq_local, irq_remote}, 0);

      wr(4'd6, 32'h0C);            // local stop and abort enables
      put_data('h100, 1, 32'h40, 64'h1000, 64'h2000);

      // R2 doorbell ignored while channel disabled
      wr(4'd2, 32'h100);
      wr(4'd4, 32'h1);
      wr(4'd5, 32'h1);
      repeat (20) @(negedge clk);
      rd(4'd9, v); chk("R2 disabled doorbell", v, 0);
      wr(4'd0, 32'h1);
      wr(4'd5, 32'h1);
      repeat (20) @(negedge clk);
      rd(4'd9, v); chk("R2 list mode off doorbell", v, 0);
      wr(4'd1, 32'h1);

      // R3 pointer high half readback
      wr(4'd3, 32'h1);
      rd(4'd3, v); chk("R3 pointer high", v, 32'h1);
      wr(4'd3, 32'h0);

      // straight run of three data elements ending on an inverted-cycle link (R3 R4)
      put_data('h118, 1, 32'h80, 64'h1100, 64'h2200);
      put_data('h130, 1, 32'h10, 64'h0000_0012_3456_7800, 64'h0000_00FF_0000_0010);
      put_link('h148, 0, 1, 32'h100);
      expect_copy(64'h1000, 64'h2000, 32'h40);
      expect_copy(64'h1100, 64'h2200, 32'h80);
      expect_copy(64'h0000_0012_3456_7800, 64'h0000_00FF_0000_0010, 32'h10);
      wr(4'd5, 32'h1);
      rd(4'd9, v); chk("R9 running after doorbell", v, 1);
      run_done("R4", 3, 32'h148);
      rd(4'd7, v); chk("R4 stop status", v, 1);
      chk("R8 local stop line", irq_local, 1);
      wr(4'd8, 32'h0);
      rd(4'd7, v); chk("R7 zero clear keeps", v, 1);
      wr(4'd8, 32'h1);
      rd(4'd7, v); chk("R7 clear stop", v, 0);
      chk("R7 line low", irq_local, 0);

      // one-element ring with toggling link (R5)
      put_data('h200, 1, 32'h20, 64'h3000, 64'h4000);
      put_link('h218, 1, 1, 32'h200);
      wr(4'd2, 32'h200);
      expect_copy(64'h3000, 64'h4000, 32'h20);
      wr(4'd5, 32'h1);
      run_done("R5 ring pass 1", 3, 32'h200);
      rd(4'd4, v); chk("R5 cycle inverted", v, 0);
      wr(4'd8, 32'h1);
      put_data('h200, 0, 32'h30, 64'h5000, 64'h6000);
      put_link('h218, 0, 1, 32'h200);
      expect_copy(64'h5000, 64'h6000, 32'h30);
      wr(4'd5, 32'h1);
      run_done("R5 ring pass 2", 3, 32'h200);
      rd(4'd4, v); chk("R5 cycle restored", v, 1);
      wr(4'd8, 32'h1);

      // non-toggling link (R5)
      put_link('h300, 1, 0, 32'h340);
      put_data('h340, 1, 32'h8, 64'h7000, 64'h7100);
      put_data('h358, 0, 32'h8, 64'h7200, 64'h7300);
      wr(4'd2, 32'h300);
      expect_copy(64'h7000, 64'h7100, 32'h8);
      wr(4'd5, 32'h1);
      run_done("R5 plain link", 3, 32'h358);
      rd(4'd4, v); chk("R5 cycle kept", v, 1);
      wr(4'd8, 32'h1);

      // zero byte count aborts (R6)
      put_data('h400, 1, 32'h0, 64'h8000, 64'h8100);
      wr(4'd2, 32'h400);
      wr(4'd5, 32'h1);
      run_done("R6 zero count", 2, 32'h400);
      rd(4'd7, v); chk("R6 abort status", v, 2);
      chk("R8 local abort line", irq_local, 1);
      wr(4'd8, 32'h2);
      rd(4'd7, v); chk("R7 clear abort", v, 0);

      // read error on the source word aborts (R6)
      put_data('h500, 1, 32'h10, 64'h9000, 64'h9100);
      err_en = 1; err_addr = 64'h508;
      wr(4'd2, 32'h500);
      wr(4'd5, 32'h1);
      run_done("R6 read error", 2, 32'h500);
      rd(4'd7, v); chk("R6 abort status on error", v, 2);
      err_en = 0;
      wr(4'd8, 32'h2);

      // local and remote routing, then masking (R8)
      wr(4'd6, 32'h14);
      put_data('h600, 1, 32'h4, 64'hA000, 64'hA100);
      put_data('h618, 0, 32'h4, 64'hA200, 64'hA300);
      wr(4'd2, 32'h600);
      expect_copy(64'hA000, 64'hA100, 32'h4);
      wr(4'd5, 32'h1);
      run_done("R8 routed", 3, 32'h618);
      chk("R8 both lines", {irq_local, irq_remote}, 2'b11);
      wr(4'd8, 32'h1);
      wr(4'd6, 32'h15);
      put_data('h618, 1, 32'h4, 64'hA200, 64'hA300);
      put_data('h630, 0, 32'h4, 64'hA400, 64'hA500);
      expect_copy(64'hA200, 64'hA300, 32'h4);
      wr(4'd5, 32'h1);
      run_done("R8 masked", 3, 32'h630);
      rd(4'd7, v); chk("R7 masked status still set", v, 1);
      chk("R8 masked lines", {irq_local, irq_remote}, 2'b00);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule